// File: doc/BRIEF.md
# Synchronous Burst PSRAM Bus Master

This block is the host-side controller for a 16-bit synchronous burst memory bus with separate address and data pins. A local client hands it one request at a time (start address, beat count, direction). The block then runs one burst on the external bus. It produces a bus clock at half the system clock rate, plus active-low chip select, address-valid, output enable, write enable and byte-lane enables. Read data is captured a fixed number of bus clocks after the address phase.

The block is built around one state machine. Its states are `ST_IDLE`, `ST_ADDR`, `ST_LAT`, `ST_DATA` and `ST_TURN`, and every move between them except the one out of `ST_TURN` happens on a system edge that raises the bus clock. The transitions are:

- **accept**: `ST_IDLE` to `ST_ADDR`, when a request is pending.
- **addr_done**: `ST_ADDR` to `ST_LAT`, or straight to `ST_DATA` when the latency is one.
- **lat_done**: `ST_LAT` to `ST_DATA`, when the latency count runs out.
- **beat_next**: `ST_DATA` to `ST_DATA`, when more beats remain.
- **burst_done**: `ST_DATA` to `ST_TURN`, after the last beat.
- **turn_done**: `ST_TURN` to `ST_IDLE`, after the turnaround system cycles have elapsed.

The client writes data one word per `wr_ack` pulse and receives one `rd_valid` pulse per word read. The slave increments the word address itself across the burst.

Top module: `psram_burst_master`

## Requirements
- R1: `bus_clk` is 0 out of reset and toggles on every system clock edge, so one bus period spans two system clocks.
- R2: Each access opens with `bus_adv_n` low for exactly one bus clock (two system cycles). During that clock `bus_cs_n` is low and `bus_addr` carries the request address. `bus_adv_n` is never low while `bus_cs_n` is high.
- R3: The first data beat occupies the bus clock that comes LATENCY (default 2) bus clocks after the address clock. For a write, `wr_ack` first rises 2·LATENCY−1 system cycles after `bus_adv_n` falls. For a read, `rd_valid` first rises 2·(LATENCY+1) system cycles after `bus_adv_n` falls.
- R4: A write burst has these properties:
  - `bus_we_n` is low and `bus_dq_oe` is high for the whole access.
  - Beat i drives `wr_data` on `bus_dq_o` in the bus clock after the i-th `wr_ack`.
  - `bus_be_n[1]` is the inverse of `wr_be[1]` and gates byte 15:8; `bus_be_n[0]` is the inverse of `wr_be[0]` and gates byte 7:0.
- R5: A read burst has these properties:
  - `bus_dq_oe` stays low and `bus_be_n` is all zero.
  - `bus_oe_n` is low from the clock after the address clock to the end of the access.
  - Each word is captured on the rising bus edge that ends its data clock.
  - Each capture produces one single-cycle `rd_valid` pulse carrying the word on `rd_data`.
- R6: `bus_oe_n` and `bus_we_n` are never low together.
- R7: Every bus output changes only on a system edge that raises `bus_clk`.
- R8: After the last beat, `bus_cs_n`, `bus_oe_n` and `bus_we_n` return high together. `bus_cs_n` then stays high for at least TURN_CYC system cycles and at least one full bus clock. `req_ready` is high only in idle, in the cycle before a rising bus edge. A request held during a burst is taken only after the turnaround.
- R9: `req_len` encodes beats minus one. A burst carries exactly `req_len`+1 words, for every value from 0 up to the field maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | Request taken at the coming edge |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Beat count minus one |
| wr_data | input | DATA_W | Write word for the current beat |
| wr_be | input | DATA_W/8 | Active-high byte enables of the write word |
| wr_ack | output | 1 | Write word consumed at the coming edge |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle strobe per captured word |
| bus_clk | output | 1 | Bus clock, half the system rate |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dq_o | output | DATA_W | Data driven toward the memory |
| bus_dq_oe | output | 1 | Data output enable |
| bus_dq_i | input | DATA_W | Data returned by the memory |

## Verification
Two functions can land on the same rising bus edge:

- the capture of the final read word, or the sampling of the final write word;
- the release of chip select, output enable and write enable that closes the burst.

A new request may also already be waiting on that edge. The bench provokes this by raising the next request as soon as the previous one has been taken, so every burst in the length sweep runs back to back with the next. The last word must still arrive intact with the exact beat count. Chip select must stay high for at least two system cycles before the next address clock. The next address must appear only after that gap.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LAT,
        ST_DATA,
        ST_TURN
    } psram_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/psram_clkgen.sv
module psram_clkgen (
    input  logic clk,
    input  logic rst_n,
    output logic bus_clk,
    output logic tick
);

    logic clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= ~clk_q;
    end

    assign bus_clk = clk_q;
    // the coming system edge raises the bus clock
    assign tick    = ~clk_q;

    // R1
    bus_clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bus_clk != $past(bus_clk)));

endmodule

// File: rtl/psram_cnt.sv
module psram_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);

    // R9
    load_dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

endmodule

// File: rtl/psram_datapath.sv
module psram_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_o     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (launch)  dq_o    <= wr_data;
            if (capture) rd_data <= dq_i;
        end
    end

    // R6
    no_launch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch && capture));

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/psram_burst_master.sv
module psram_burst_master
    import psram_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int LEN_W    = 4,
    parameter int LATENCY  = 2,
    parameter int TURN_CYC = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_be,
    output logic                  wr_ack,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  bus_clk,
    output logic                  bus_cs_n,
    output logic                  bus_adv_n,
    output logic                  bus_oe_n,
    output logic                  bus_we_n,
    output logic [DATA_W/8-1:0]   bus_be_n,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_dq_o,
    output logic                  bus_dq_oe,
    input  logic [DATA_W-1:0]     bus_dq_i
);

    localparam int BE_W    = DATA_W / 8;
    localparam int CNT_W   = max3(LEN_W, $clog2(LATENCY + 1), $clog2(TURN_CYC + 1));
    localparam bit HAS_LAT = (LATENCY > 1);
    localparam int LAT_LD  = HAS_LAT ? (LATENCY - 2) : 0;
    localparam int TRN_LD  = (TURN_CYC > 0) ? (TURN_CYC - 1) : 0;

    psram_state_e     state_q, state_nx;
    logic             tick;
    logic             accept;
    logic             write_q;
    logic [LEN_W-1:0] len_q;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             capture;

    psram_clkgen u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_clk (bus_clk),
        .tick    (tick)
    );

    psram_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    assign req_ready = tick && (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign wr_ack    = tick && (state_nx == ST_DATA) && write_q;
    assign capture   = tick && (state_q == ST_DATA) && !write_q;

    psram_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (wr_ack),
        .wr_data  (wr_data),
        .capture  (capture),
        .dq_i     (bus_dq_i),
        .dq_o     (bus_dq_o),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // next-state and counter control
    always_comb begin
        state_nx = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (tick) begin
                    cnt_load = 1'b1;
                    if (HAS_LAT) begin
                        state_nx = ST_LAT;
                        cnt_val  = CNT_W'(LAT_LD);
                    end else begin
                        state_nx = ST_DATA;
                        cnt_val  = CNT_W'(len_q);
                    end
                end
            end
            ST_LAT: begin
                if (tick) begin
                    if (cnt_zero) begin
                        state_nx = ST_DATA;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(len_q);
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (cnt_zero) begin
                        state_nx = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(TRN_LD);
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_zero) state_nx = ST_IDLE;
                else          cnt_dec  = 1'b1;
            end
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
            len_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                write_q <= req_write;
                len_q   <= req_len;
            end
        end
    end

    // bus strobes, updated only on rising bus edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_cs_n  <= 1'b1;
            bus_adv_n <= 1'b1;
            bus_oe_n  <= 1'b1;
            bus_we_n  <= 1'b1;
            bus_be_n  <= '1;
            bus_addr  <= '0;
            bus_dq_oe <= 1'b0;
        end else if (tick) begin
            unique case (state_nx)
                ST_ADDR: begin
                    bus_cs_n  <= 1'b0;
                    bus_adv_n <= 1'b0;
                    bus_oe_n  <= 1'b1;
                    bus_we_n  <= !req_write;
                    bus_be_n  <= req_write ? {BE_W{1'b1}} : {BE_W{1'b0}};
                    bus_addr  <= req_addr;
                    bus_dq_oe <= req_write;
                end
                ST_LAT: begin
                    bus_cs_n  <= 1'b0;
                    bus_adv_n <= 1'b1;
                    bus_oe_n  <= write_q;
                    bus_we_n  <= !write_q;
                    bus_be_n  <= write_q ? {BE_W{1'b1}} : {BE_W{1'b0}};
                    bus_dq_oe <= write_q;
                end
                ST_DATA: begin
                    bus_cs_n  <= 1'b0;
                    bus_adv_n <= 1'b1;
                    bus_oe_n  <= write_q;
                    bus_we_n  <= !write_q;
                    bus_be_n  <= write_q ? ~wr_be : {BE_W{1'b0}};
                    bus_dq_oe <= write_q;
                end
                ST_IDLE, ST_TURN: begin
                    bus_cs_n  <= 1'b1;
                    bus_adv_n <= 1'b1;
                    bus_oe_n  <= 1'b1;
                    bus_we_n  <= 1'b1;
                    bus_be_n  <= '1;
                    bus_dq_oe <= 1'b0;
                end
            endcase
        end
    end

    // R6
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    // R2
    adv_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_adv_n |-> !bus_cs_n);

    // R2
    adv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_adv_n && !$past(bus_adv_n)) |=> bus_adv_n);

    // R7
    edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_be_n, bus_addr, bus_dq_oe, bus_dq_o})
        |-> bus_clk);

    // R4
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_oe |-> (!bus_we_n && bus_oe_n));

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |=> bus_cs_n);

    // R8
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_oe_n && bus_we_n && !bus_dq_oe));

    // R5
    rd_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bus_we_n && !bus_dq_oe));

endmodule

// File: tb/test_psram_burst_master.sv
module test_psram_burst_master;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 4;
    localparam int LAT    = 2;
    localparam int BE_W   = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [BE_W-1:0]   wr_be = '0;
    logic              wr_ack;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              bus_clk, bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_dq_oe;
    logic [BE_W-1:0]   bus_be_n;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dq_o;
    logic [DATA_W-1:0] bus_dq_i = '0;

    always #2.5 clk = ~clk;

    psram_burst_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LATENCY(LAT), .TURN_CYC(1)
    ) i_psram_burst_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_be(wr_be), .wr_ack(wr_ack),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_clk(bus_clk), .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_be_n(bus_be_n),
        .bus_addr(bus_addr), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
        .bus_dq_i(bus_dq_i)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // slave memory and the bench's own expectation of its contents
    logic [DATA_W-1:0] s_mem [64];
    logic [DATA_W-1:0] shadow [64];
    logic [DATA_W-1:0] exp_q [1024];
    int q_head = 0, q_tail = 0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            s_mem[i]  = DATA_W'(i * 7 + 16'h3100);
            shadow[i] = DATA_W'(i * 7 + 16'h3100);
        end
    end

    // behavioural slave: acts on system edges that raise the bus clock
    logic [5:0] s_base = '0;
    int         s_cyc = 0;
    bit         s_read = 1'b0;
    always @(posedge clk) begin
        if (rst_n && !bus_clk && !bus_cs_n) begin
            int         nc;
            logic [5:0] nb;
            bit         rd;
            if (!bus_adv_n) begin
                s_base <= bus_addr[5:0];
                s_cyc  <= 1;
                s_read <= bus_we_n;
                nc = 1;
                nb = bus_addr[5:0];
                rd = bus_we_n;
            end else begin
                if (!bus_we_n && s_cyc >= LAT) begin
                    logic [5:0] wa;
                    wa = s_base + 6'(s_cyc - LAT);
                    if (!bus_be_n[1]) s_mem[wa][15:8] <= bus_dq_o[15:8];
                    if (!bus_be_n[0]) s_mem[wa][7:0]  <= bus_dq_o[7:0];
                end
                s_cyc <= s_cyc + 1;
                nc = s_cyc + 1;
                nb = s_base;
                rd = s_read;
            end
            if (rd && nc >= LAT) bus_dq_i <= s_mem[nb + 6'(nc - LAT)];
        end
    end

    // monitor, sampled between edges
    int  cyc = 0;
    bit  mon_on = 1'b0;
    logic prev_clk, prev_cs, prev_adv, prev_rv;
    logic [63:0] prev_vec;
    int  t_adv = 0, adv_run = 0, cs_hi_run = 0;
    bit  acc_wr = 1'b0, first_beat = 1'b0, had_acc = 1'b0;
    int  ack_cnt = 0, rd_cnt = 0, exp_len = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always @(negedge clk) begin
        logic [63:0] vec;
        vec = 64'({bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_be_n, bus_addr, bus_dq_oe, bus_dq_o});
        if (rst_n) begin
            cyc++;
            if (mon_on) begin
                // R1
                chk(bus_clk != prev_clk, "R1 bus clock toggle", bus_clk, !prev_clk);
                // R6
                chk(!(!bus_oe_n && !bus_we_n), "R6 oe/we overlap", {bus_oe_n, bus_we_n}, 2'b11);
                // R7
                if (vec != prev_vec) chk(bus_clk == 1'b1, "R7 change off rising edge", bus_clk, 1);
                // R2 address phase opening
                if (!bus_adv_n && prev_adv) begin
                    t_adv = cyc; acc_wr = !bus_we_n; first_beat = 1'b1;
                    ack_cnt = 0; rd_cnt = 0; adv_run = 0;
                    chk(!bus_cs_n, "R2 cs low with adv", bus_cs_n, 0);
                    chk(bus_addr == exp_addr, "R2 address", bus_addr, exp_addr);
                end
                if (!bus_adv_n) adv_run++;
                if (bus_adv_n && !prev_adv) chk(adv_run == 2, "R2 adv width", adv_run, 2);
                // R4 write beats
                if (wr_ack) begin
                    if (first_beat) begin
                        chk(cyc == t_adv + 2*LAT - 1, "R3 write latency", cyc - t_adv, 2*LAT - 1);
                        first_beat = 1'b0;
                    end
                    chk(bus_dq_oe && !bus_we_n, "R4 write drive", {bus_dq_oe, bus_we_n}, 2'b10);
                    ack_cnt++;
                end
                // R5 read beats
                if (rd_valid) begin
                    if (first_beat) begin
                        chk(cyc == t_adv + 2*(LAT+1), "R3 read latency", cyc - t_adv, 2*(LAT+1));
                        first_beat = 1'b0;
                    end
                    chk(!prev_rv, "R5 single-cycle rd_valid", prev_rv, 0);
                    if (q_head < q_tail) begin
                        chk(rd_data == exp_q[q_head], "R5 read data", rd_data, exp_q[q_head]);
                        q_head++;
                    end else begin
                        chk(1'b0, "R5 unexpected read word", rd_data, 0);
                    end
                    rd_cnt++;
                end
                if (!bus_oe_n) chk(!bus_dq_oe && bus_be_n == '0, "R5 read lanes", {bus_dq_oe, bus_be_n}, 0);
                // R8 close and turnaround
                if (bus_cs_n && !prev_cs) begin
                    chk(bus_oe_n && bus_we_n, "R8 strobes released", {bus_oe_n, bus_we_n}, 2'b11);
                    if (acc_wr) chk(ack_cnt == exp_len, "R9 write beat count", ack_cnt, exp_len);
                    else        chk(rd_cnt == exp_len, "R9 read beat count", rd_cnt, exp_len);
                    cs_hi_run = 0;
                    had_acc = 1'b1;
                end
                if (bus_cs_n) cs_hi_run++;
                if (!bus_cs_n && prev_cs && had_acc) chk(cs_hi_run >= 2, "R8 turnaround gap", cs_hi_run, 2);
                if (req_ready) chk(bus_cs_n, "R8 ready only when idle", bus_cs_n, 1);
            end
            mon_on   = 1'b1;
            prev_clk = bus_clk;
            prev_cs  = bus_cs_n;
            prev_adv = bus_adv_n;
            prev_rv  = rd_valid;
            prev_vec = vec;
        end
    end

    function automatic logic [DATA_W-1:0] wdat(input int len, input int b, input int base);
        return DATA_W'(len * 4099 + b * 257 + base * 13 + 16'h0a05);
    endfunction

    task automatic issue(input bit wr, input int base, input int len);
        @(negedge clk);
        req_write = wr;
        req_addr  = ADDR_W'(base);
        req_len   = LEN_W'(len - 1);
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        exp_addr = ADDR_W'(base);
        exp_len  = len;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic write_burst(input int base, input int len);
        wr_data = wdat(len, 0, base);
        wr_be   = BE_W'((len) % 4);
        issue(1'b1, base, len);
        for (int b = 0; b < len; b++) begin
            logic [5:0] a;
            while (!wr_ack) @(negedge clk);
            a = 6'(base + b);
            if (wr_be[1]) shadow[a][15:8] = wr_data[15:8];
            if (wr_be[0]) shadow[a][7:0]  = wr_data[7:0];
            @(posedge clk); #1;
            wr_data = wdat(len, b + 1, base);
            wr_be   = BE_W'((b + 1 + len) % 4);
            @(negedge clk);
        end
    endtask

    task automatic read_burst(input int base, input int len);
        for (int b = 0; b < len; b++) begin
            exp_q[q_tail] = shadow[6'(base + b)];
            q_tail++;
        end
        issue(1'b0, base, len);
    endtask

    initial begin
        #1;
        repeat (4) @(negedge clk);
        // reset state
        chk(bus_cs_n && bus_adv_n && bus_oe_n && bus_we_n, "R8 reset strobes",
            {bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n}, 4'hf);
        chk(!bus_dq_oe && !rd_valid && !wr_ack, "R5 reset data side",
            {bus_dq_oe, rd_valid, wr_ack}, 0);
        chk(bus_clk == 1'b0, "R1 reset bus clock", bus_clk, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(bus_cs_n, "R8 idle without request", bus_cs_n, 1);
        // sweep every burst length, write then read back, back to back
        for (int len = 1; len <= (1 << LEN_W); len++) begin
            write_burst((len * 5) % 64, len);
            read_burst((len * 5) % 64, len);
        end
        // full read-back of the whole memory
        for (int k = 0; k < 4; k++) read_burst(k * 16, 16);
        while (q_head < q_tail) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(q_head == q_tail && q_tail == 4*16 + 136, "R9 total read words", q_head, 4*16 + 136);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule